// File: doc/BRIEF.md
# Flag-Setting Arithmetic and Compare Unit

This block is the combinational execute unit of a small 16-bit load/store core. Every cycle it takes two register operands and a 6-bit operation code. It returns a register result together with a register-write enable, or a new condition flag together with a flag-write enable. The operand on `src_a` comes from the source register field. The operand on `src_b` comes from the destination register field.

The top bit of the operation code divides the codes into two families. When it is clear, the operation is an arithmetic, logic or shift operation: it writes a register and never touches the condition flag. When it is set, the operation is a comparison: it only rewrites the flag and never writes a register. A code outside the defined set drives all outputs to zero, so the surrounding pipeline treats it as a bubble.

The block has no state and no states of its own. The decoder sorts each code into one of three named classes: `K_DATA` (writes a register), `K_COND` (writes the flag) and `K_NONE` (undefined). The outputs are selected from that class in the same cycle. No class depends on any earlier one, so there are no transitions.

Top module: `flagalu`

## Requirements
- R1: The codes 000000 to 001000 (ADD, SUB, AND, OR, XOR, NOT, SHL, SHR, ASR) assert `result_we`, deassert `cond_we` and hold `cond_out` at 0.
- R2: The codes 100000 to 100101 assert `cond_we`, deassert `result_we` and drive `result` to 0.
- R3: ADD (000000) gives `src_a + src_b` and SUB (000001) gives `src_a - src_b`. Both wrap modulo 2^16, and no carry or overflow is reported.
- R4: AND (000010), OR (000011) and XOR (000100) give the bitwise combination of `src_a` and `src_b`.
- R5: NOT (000101) gives the bitwise inverse of `src_a`, whatever the value of `src_b`.
- R6: SHL (000110) shifts `src_a` left by one and fills with 0. SHR (000111) shifts it right by one and fills with 0. ASR (001000) shifts it right by one and copies bit 15 into the top position.
- R7: EQ (100000) sets `cond_out` when `src_a == src_b`. NE (100001) sets it when the two operands differ.
- R8: GT (100010) sets `cond_out` when `src_a > src_b`, and LT (100011) sets it when `src_a < src_b`. Both compare the operands as unsigned values.
- R9: EZ (100100) sets `cond_out` when `src_a` is zero, and NZ (100101) sets it when `src_a` is nonzero. `src_b` has no effect on either.
- R10: Any other code drives `result`, `result_we`, `cond_out` and `cond_we` all to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 16 | Operand from the source register field |
| src_b | input | 16 | Operand from the destination register field |
| op_code | input | 6 | Operation code; bit 5 selects the compare family |
| result | output | 16 | Register result; 0 when `result_we` is low |
| result_we | output | 1 | Register write request |
| cond_out | output | 1 | New condition flag value; 0 when `cond_we` is low |
| cond_we | output | 1 | Condition flag write request |

## Verification
The hardest cases to reach are the ones whose effect is invisible unless the operand values are chosen carefully. Examples are `src_b` having no effect on EZ, NZ and NOT, and GT or LT being unsigned rather than signed. The stimulus pairs each of these codes with a zero `src_a` and a nonzero `src_b`, and the reverse. It also uses operands with bit 15 set on one side only, so that a signed compare or a wrong operand choice flips the flag. A sweep over all 64 codes with fixed operands then confirms that every undefined code is silent.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;

    localparam int OPW = 6;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 6'b000000,
        OP_SUB = 6'b000001,
        OP_AND = 6'b000010,
        OP_OR  = 6'b000011,
        OP_XOR = 6'b000100,
        OP_NOT = 6'b000101,
        OP_SHL = 6'b000110,
        OP_SHR = 6'b000111,
        OP_ASR = 6'b001000,
        OP_CEQ = 6'b100000,
        OP_CNE = 6'b100001,
        OP_CGT = 6'b100010,
        OP_CLT = 6'b100011,
        OP_CEZ = 6'b100100,
        OP_CNZ = 6'b100101
    } alu_op_e;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_DATA = 2'd1,
        K_COND = 2'd2
    } op_kind_e;

endpackage

// File: rtl/flagalu_decode.sv
module flagalu_decode
    import flagalu_pkg::*;
(
    input  logic [OPW-1:0] op_code,
    output op_kind_e       kind,
    output logic           data_we,
    output logic           flag_we
);

    always_comb begin
        kind = K_NONE;
        unique case (alu_op_e'(op_code))
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
            OP_NOT, OP_SHL, OP_SHR, OP_ASR:          kind = K_DATA;
            OP_CEQ, OP_CNE, OP_CGT, OP_CLT,
            OP_CEZ, OP_CNZ:                          kind = K_COND;
            default:                                 kind = K_NONE;
        endcase
    end

    always_comb begin
        data_we = (kind == K_DATA);
        flag_we = (kind == K_COND);
    end

endmodule

// File: rtl/flagalu_datapath.sv
module flagalu_datapath
    import flagalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic [OPW-1:0] op_code,
    output logic [W-1:0]   value
);

    localparam int MSB = W - 1;

    always_comb begin
        value = '0;
        case (alu_op_e'(op_code))
            OP_ADD:  value = opa + opb;
            OP_SUB:  value = opa - opb;
            OP_AND:  value = opa & opb;
            OP_OR:   value = opa | opb;
            OP_XOR:  value = opa ^ opb;
            OP_NOT:  value = ~opa;
            OP_SHL:  value = {opa[MSB-1:0], 1'b0};
            OP_SHR:  value = {1'b0, opa[MSB:1]};
            OP_ASR:  value = {opa[MSB], opa[MSB:1]};
            default: value = '0;
        endcase
    end

endmodule

// File: rtl/flagalu_compare.sv
module flagalu_compare
    import flagalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic [OPW-1:0] op_code,
    output logic           hit
);

    logic same;
    logic above;
    logic below;
    logic a_zero;

    always_comb begin
        same   = (opa == opb);
        above  = (opa > opb);
        below  = (opa < opb);
        a_zero = (opa == '0);
    end

    always_comb begin
        hit = 1'b0;
        case (alu_op_e'(op_code))
            OP_CEQ:  hit = same;
            OP_CNE:  hit = !same;
            OP_CGT:  hit = above;
            OP_CLT:  hit = below;
            OP_CEZ:  hit = a_zero;
            OP_CNZ:  hit = !a_zero;
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        AST_ORDER_SINGLE: assert (!(above && below)); // R8
    end

endmodule

// File: rtl/flagalu.sv
module flagalu
    import flagalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]   src_a,
    input  logic [W-1:0]   src_b,
    input  logic [OPW-1:0] op_code,
    output logic [W-1:0]   result,
    output logic           result_we,
    output logic           cond_out,
    output logic           cond_we
);

    op_kind_e       kind;
    logic           data_we;
    logic           flag_we;
    logic [W-1:0]   dp_value;
    logic           cmp_hit;

    flagalu_decode u_decode (
        .op_code (op_code),
        .kind    (kind),
        .data_we (data_we),
        .flag_we (flag_we)
    );

    flagalu_datapath #(.W(W)) u_datapath (
        .opa     (src_a),
        .opb     (src_b),
        .op_code (op_code),
        .value   (dp_value)
    );

    flagalu_compare #(.W(W)) u_compare (
        .opa     (src_a),
        .opb     (src_b),
        .op_code (op_code),
        .hit     (cmp_hit)
    );

    always_comb begin
        result    = data_we ? dp_value : '0;
        result_we = data_we;
        cond_out  = flag_we ? cmp_hit : 1'b0;
        cond_we   = flag_we;
    end

    always_comb begin
        if (!op_code[OPW-1]) begin
            AST_DATA_KEEPS_FLAG: assert (!cond_we && !cond_out); // R1
        end
        if (op_code[OPW-1]) begin
            AST_CMP_NO_WRITE: assert (!result_we && result == '0); // R2
        end
        AST_WE_EXCLUSIVE: assert (!(result_we && cond_we)); // R2
        if (kind == K_NONE) begin
            AST_UNDEF_QUIET: assert (!result_we && !cond_we && result == '0 && !cond_out); // R10
        end
    end

endmodule

// File: tb/flagalu_tb.sv
module flagalu_tb;

    localparam int W = 16;

    typedef struct {
        logic [5:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] res;
        logic         rwe;
        logic         c;
        logic         cwe;
        string        tag;
        string        wtag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic [5:0]   op_code = '0;
    logic [W-1:0] result;
    logic         result_we;
    logic         cond_out;
    logic         cond_we;

    int   total = 0;
    int   bad = 0;
    bit   drive_done = 0;
    bit   finished = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    flagalu u_dut (
        .src_a     (src_a),
        .src_b     (src_b),
        .op_code   (op_code),
        .result    (result),
        .result_we (result_we),
        .cond_out  (cond_out),
        .cond_we   (cond_we)
    );

    function automatic exp_t model(input logic [5:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        exp_t e;
        e.op = op; e.a = a; e.b = b;
        e.res = '0; e.rwe = 1'b0; e.c = 1'b0; e.cwe = 1'b0;
        e.tag = "R10"; e.wtag = "R10";
        case (op)
            6'b000000: begin e.res = a + b;                e.tag = "R3"; end
            6'b000001: begin e.res = a - b;                e.tag = "R3"; end
            6'b000010: begin e.res = a & b;                e.tag = "R4"; end
            6'b000011: begin e.res = a | b;                e.tag = "R4"; end
            6'b000100: begin e.res = a ^ b;                e.tag = "R4"; end
            6'b000101: begin e.res = ~a;                   e.tag = "R5"; end
            6'b000110: begin e.res = a << 1;               e.tag = "R6"; end
            6'b000111: begin e.res = a >> 1;               e.tag = "R6"; end
            6'b001000: begin e.res = {a[W-1], a[W-1:1]};   e.tag = "R6"; end
            6'b100000: begin e.c = (a == b);               e.tag = "R7"; end
            6'b100001: begin e.c = (a != b);               e.tag = "R7"; end
            6'b100010: begin e.c = (a > b);                e.tag = "R8"; end
            6'b100011: begin e.c = (a < b);                e.tag = "R8"; end
            6'b100100: begin e.c = (a == '0);              e.tag = "R9"; end
            6'b100101: begin e.c = (a != '0);              e.tag = "R9"; end
            default: ;
        endcase
        if (op <= 6'b001000) begin e.rwe = 1'b1; e.wtag = "R1"; end
        else if (op >= 6'b100000 && op <= 6'b100101) begin e.cwe = 1'b1; e.wtag = "R2"; end
        return e;
    endfunction

    task automatic drive(input logic [5:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        #1;
        op_code = op; src_a = a; src_b = b;
        sb_q.push_back(model(op, a, b));
    endtask

    task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp, input logic [5:0] op);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s op=%b actual=%h expected=%h", req, what, op, act, exp);
        end
    endtask

    // monitor: compare at the falling edge, away from input changes
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag,  "result",    result,               e.res,               e.op);
                check(e.wtag, "result_we", {{(W-1){1'b0}}, result_we}, {{(W-1){1'b0}}, e.rwe}, e.op);
                check(e.tag,  "cond_out",  {{(W-1){1'b0}}, cond_out},  {{(W-1){1'b0}}, e.c},   e.op);
                check(e.wtag, "cond_we",   {{(W-1){1'b0}}, cond_we},   {{(W-1){1'b0}}, e.cwe}, e.op);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // state right after reset: all-zero inputs decode as ADD 0+0 (R1, R3)
        drive(6'b000000, 16'h0000, 16'h0000);
        // R3: wraparound in both directions
        drive(6'b000000, 16'hFFFF, 16'h0001);
        drive(6'b000000, 16'h1234, 16'h4321);
        drive(6'b000001, 16'h0000, 16'h0001);
        drive(6'b000001, 16'h9000, 16'h1001);
        // R4
        drive(6'b000010, 16'hF0F0, 16'hFF00);
        drive(6'b000011, 16'hF0F0, 16'h0F01);
        drive(6'b000100, 16'hAAAA, 16'hFFFF);
        // R5: src_b has no effect
        drive(6'b000101, 16'h00FF, 16'h0000);
        drive(6'b000101, 16'h00FF, 16'hFFFF);
        // R6: edge bits
        drive(6'b000110, 16'h8001, 16'h0000);
        drive(6'b000111, 16'h8001, 16'hFFFF);
        drive(6'b001000, 16'h8001, 16'h0000);
        drive(6'b001000, 16'h4002, 16'h0000);
        // R7
        drive(6'b100000, 16'h5A5A, 16'h5A5A);
        drive(6'b100000, 16'h5A5A, 16'h5A5B);
        drive(6'b100001, 16'h5A5A, 16'h5A5A);
        drive(6'b100001, 16'h0001, 16'h8001);
        // R8: unsigned with bit 15 on one side, and equal operands
        drive(6'b100010, 16'h8000, 16'h7FFF);
        drive(6'b100010, 16'h7FFF, 16'h8000);
        drive(6'b100010, 16'h1234, 16'h1234);
        drive(6'b100011, 16'h7FFF, 16'h8000);
        drive(6'b100011, 16'h8000, 16'h7FFF);
        drive(6'b100011, 16'h1234, 16'h1234);
        // R9: src_b has no effect
        drive(6'b100100, 16'h0000, 16'hFFFF);
        drive(6'b100100, 16'h0100, 16'h0000);
        drive(6'b100101, 16'h0000, 16'h0001);
        drive(6'b100101, 16'h8000, 16'h0000);
        // R10 and full classification: sweep all codes
        for (int k = 0; k < 64; k++) begin
            drive(6'(k), 16'hC3A5, 16'h3C5A);
        end
        for (int k = 0; k < 64; k++) begin
            drive(6'(k), 16'h0000, 16'h8001);
        end
        drive_done = 1;
    end

    initial begin
        wait (drive_done);
        wait (sb_q.size() == 0);
        @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule